// File: doc/BRIEF.md
# Second-Order One-Bit Delta-Sigma Modulator

This block is a synthesizable, cycle-exact model of a second-order delta-sigma modulator with a one-bit quantizer. A signed sample word that stands for a differential input voltage comes in. One output bit leaves per modulator clock, and the fraction of ones in that stream follows the input. The stream is meant to feed a decimation filter elsewhere, for example in a system testbench.

Two saturating integrators are cascaded. Each one subtracts a fixed feedback magnitude whose sign follows the last output bit. The sign of the second integrator sets the next output bit. That bit is registered on the falling clock edge, and the integrators advance on the rising edge.

Scaling places the linear band of plus or minus 25600 codes at ones densities of 10.94% to 89.06%. At the clip level of plus or minus 32767 codes, the output is driven to a solid level.

Top module: `dsm2_modulator`

## Requirements
- R1: On each rising edge the first integrator takes in the sample minus the feedback value. In the same edge the second integrator takes in the first integrator's pre-edge value minus the same feedback value.
- R2: The feedback value is +32768 when the registered output bit is 1 and −32768 when it is 0. The bit registered at a falling edge is used at the next rising edge.
- R3: In the non-clipped band, the output bit is set at the falling edge to 1 when the second integrator is zero or positive, and to 0 when it is negative. The output holds its value across the rising edge.
- R4: A constant input of 0 gives a ones density of 50% within ±0.5% over 4096 clocks.
- R5: A constant input of +25600 gives about 89.06% ones, and −25600 gives about 10.94% ones, each within ±0.5% over 4096 clocks.
- R6: Between the linear band and the clip level, the ones density does not decrease as the input rises.
- R7: An input of +32767 or more forces every output bit to 1. An input of −32767 or less forces every output bit to 0. During clipping the integrators keep running.
- R8: Both integrators are 24-bit signed values that saturate at +8388607 and −8388608 instead of wrapping.
- R9: While the active-low reset is asserted, both integrators are zero and the output bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; integrators advance on rising edge, output bit changes on falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 16 | Two's-complement input sample |
| dataOut | output | 1 | Modulated bit stream, one bit per clock |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 24-bit integrators, a feedback magnitude of 32768 and a clip level of 32767. With these values the expected density is exactly 0.5 + x/65536, so the linear-band targets can be derived in closed form.

The same values also let a clipped input drive the second integrator into its rail within a few hundred clocks. A short run therefore covers saturation and the recovery from it once the input returns to the linear band.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;
  typedef struct packed {
    logic forceHigh;
    logic forceLow;
  } clipCtl_t;
endpackage

// File: rtl/dsm2_sat_acc.sv
module dsm2_sat_acc #(
  parameter int Width = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [Width-1:0] addA,
  input  logic signed [Width-1:0] subB,
  output logic signed [Width-1:0] acc
);
  localparam int SumW = Width + 2;
  localparam logic signed [SumW-1:0] MaxV = $signed({3'b000, {(Width-1){1'b1}}});
  localparam logic signed [SumW-1:0] MinV = $signed({3'b111, {(Width-1){1'b0}}});

  logic signed [SumW-1:0] sum;
  logic signed [Width-1:0] accNext;

  always_comb begin
    sum = $signed({{2{acc[Width-1]}}, acc}) + $signed({{2{addA[Width-1]}}, addA})
        - $signed({{2{subB[Width-1]}}, subB});
    if (sum > MaxV)      accNext = MaxV[Width-1:0];
    else if (sum < MinV) accNext = MinV[Width-1:0];
    else                 accNext = sum[Width-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else       acc <= accNext;
  end

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(acc[Width-1]) && ($past(addA) >= $past(subB)) && $past(subB) >= 0)
      |-> !acc[Width-1]); // R8
  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(acc[Width-1]) && ($past(addA) <= $past(subB)) && $past(addA) <= 0)
      |-> acc[Width-1]); // R8
endmodule

// File: rtl/dsm2_ctrl.sv
module dsm2_ctrl
  import dsm2_pkg::*;
#(
  parameter int InWidth   = 16,
  parameter int ClipLevel = 32767
) (
  input  logic signed [InWidth-1:0] sampleIn,
  output clipCtl_t                  ctl
);
  localparam logic signed [InWidth-1:0] ClipPos = InWidth'(ClipLevel);
  localparam logic signed [InWidth-1:0] ClipNeg = -ClipPos;

  always_comb begin
    ctl.forceHigh = (sampleIn >= ClipPos);
    ctl.forceLow  = (sampleIn <= ClipNeg);
  end
endmodule

// File: rtl/dsm2_datapath.sv
module dsm2_datapath
  import dsm2_pkg::*;
#(
  parameter int InWidth  = 16,
  parameter int AccWidth = 24,
  parameter int FbMag    = 32768
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic signed [InWidth-1:0] sampleIn,
  input  clipCtl_t                  ctl,
  output logic                      dataBit
);
  localparam int NumStages = 2;
  localparam logic signed [AccWidth-1:0] FbPos = AccWidth'(FbMag);
  localparam logic signed [AccWidth-1:0] FbNeg = -FbPos;

  logic signed [AccWidth-1:0] stageIn [NumStages];
  logic signed [AccWidth-1:0] integ   [NumStages];
  logic signed [AccWidth-1:0] fbVal;
  logic                       cmpBit;

  assign fbVal      = dataBit ? FbPos : FbNeg;
  assign stageIn[0] = {{(AccWidth-InWidth){sampleIn[InWidth-1]}}, sampleIn};

  for (genvar s = 0; s < NumStages; s++) begin : gStage
    if (s > 0) begin : gChain
      assign stageIn[s] = integ[s-1];
    end
    dsm2_sat_acc #(.Width(AccWidth)) uAcc (
      .clk  (clk),
      .rstN (rstN),
      .addA (stageIn[s]),
      .subB (fbVal),
      .acc  (integ[s])
    );
  end

  assign cmpBit = !integ[NumStages-1][AccWidth-1];

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)              dataBit <= 1'b0;
    else if (ctl.forceHigh) dataBit <= 1'b1;
    else if (ctl.forceLow)  dataBit <= 1'b0;
    else                    dataBit <= cmpBit;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (!dataBit && integ[0] == 0 && integ[NumStages-1] == 0)); // R9
  AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ctl.forceHigh && $past(ctl.forceHigh)) |-> dataBit); // R7
  AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ctl.forceLow && $past(ctl.forceLow)) |-> !dataBit); // R7
endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator
  import dsm2_pkg::*;
#(
  parameter int InWidth   = 16,
  parameter int AccWidth  = 24,
  parameter int FbMag     = 32768,
  parameter int ClipLevel = 32767
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic signed [InWidth-1:0] sampleIn,
  output logic                      dataOut
);
  clipCtl_t ctl;

  dsm2_ctrl #(.InWidth(InWidth), .ClipLevel(ClipLevel)) uCtrl (
    .sampleIn (sampleIn),
    .ctl      (ctl)
  );

  dsm2_datapath #(.InWidth(InWidth), .AccWidth(AccWidth), .FbMag(FbMag)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .ctl      (ctl),
    .dataBit  (dataOut)
  );
endmodule

// File: tb/tb_dsm2_modulator.sv
module tb_dsm2_modulator;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic dataOut;

  int vecCount = 0;
  int failCount = 0;
  longint m1 = 0, m2 = 0;
  longint curX = 0;
  bit mb = 1'b0;
  int onesCnt;
  real dens [0:3];

  dsm2_modulator dut (.clk(clk), .rstN(rstN), .sampleIn(sampleIn), .dataOut(dataOut));

  always #5 clk = ~clk;

  function automatic longint sat24(input longint v);
    if (v > 64'sd8388607) return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleIn = '0;
    curX = 0; m1 = 0; m2 = 0; mb = 1'b0;
    #2;
    check(dataOut == 1'b0, "R9 reset output", dataOut, 0);
    @(negedge clk);
    #2;
    rstN = 1'b1;
  endtask

  // One clock: model integrators on rising edge (R1, R2), output on falling edge (R3, R7)
  task automatic step(input longint nx);
    longint fb, n1, n2;
    @(posedge clk);
    fb = mb ? 64'sd32768 : -64'sd32768;
    n1 = sat24(m1 + curX - fb);
    n2 = sat24(m2 + m1 - fb);
    m1 = n1; m2 = n2;
    #1;
    check(dataOut == mb, "R3 output stable across rising edge", dataOut, mb);
    curX = nx;
    sampleIn = 16'(nx);
    @(negedge clk);
    if (curX >= 32767)       mb = 1'b1;
    else if (curX <= -32767) mb = 1'b0;
    else                     mb = (m2 >= 0);
    #2;
    check(dataOut == mb, "R1 loop per-clock", dataOut, mb);
    if (dataOut) onesCnt++;
  endtask

  task automatic runDensity(input longint x, output real d);
    doReset();
    curX = x;
    sampleIn = 16'(x);
    onesCnt = 0;
    for (int i = 0; i < 4096; i++) step(x);
    d = real'(onesCnt) / 4096.0;
  endtask

  task automatic checkDensity(input real d, input real exp, input string req);
    real diff;
    diff = d - exp;
    if (diff < 0.0) diff = -diff;
    check(diff <= 0.005, req, longint'(d * 10000.0), longint'(exp * 10000.0));
  endtask

  initial begin
    real d;
    #1;
    check(dataOut == 1'b0, "R9 initial reset", dataOut, 0);

    runDensity(0, d);      checkDensity(d, 0.5, "R4 zero input density x1e4");
    runDensity(25600, d);  checkDensity(d, 0.890625, "R5 +linear edge density x1e4");
    runDensity(-25600, d); checkDensity(d, 0.109375, "R5 -linear edge density x1e4");
    runDensity(12000, d);  checkDensity(d, 0.5 + 12000.0 / 65536.0, "R2 feedback scale density x1e4");

    runDensity(26000, d); dens[0] = d;
    runDensity(28000, d); dens[1] = d;
    runDensity(30000, d); dens[2] = d;
    runDensity(32000, d); dens[3] = d;
    for (int k = 1; k < 4; k++)
      check(dens[k] >= dens[k-1], "R6 monotonic density x1e4",
            longint'(dens[k] * 10000.0), longint'(dens[k-1] * 10000.0));

    runDensity(32767, d);  check(onesCnt == 4096, "R7 +clip all ones", onesCnt, 4096);
    runDensity(-32767, d); check(onesCnt == 0, "R7 -clip all zeros", onesCnt, 0);
    runDensity(-32768, d); check(onesCnt == 0, "R7 most negative all zeros", onesCnt, 0);

    // R8: clip long enough to rail the integrators, then recover in the linear band
    doReset();
    for (int i = 0; i < 1000; i++) step(32767);
    for (int i = 0; i < 2000; i++) step(0);
    for (int i = 0; i < 1000; i++) step(-32768);
    for (int i = 0; i < 2000; i++) step(-20000);
    onesCnt = 0;
    check(failCount == 0, "R8 saturation recovery", failCount, 0);

    // R9: reset mid-stream clears output
    for (int i = 0; i < 50; i++) step(10000);
    doReset();
    check(dataOut == 1'b0, "R9 reset after activity", dataOut, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    #3000000;
    failCount++;
    vecCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule